// File: doc/BRIEF.md
# I2C Master Bit Timing Generator

This block is the bit-level engine of an I2C master. It takes one bus primitive at a time: a START, a repeated START, one written data bit, one read data bit, or a STOP. For each one it produces the SCL and SDA waveform with programmed timing, and it drives both lines as open-drain pull enables. Framing into bytes, addressing, acknowledge handling and arbitration belong to the layer above it.

Every interval is a whole number of prescaled ticks. One tick lasts 2^(scale+1) system clocks. Five fields set the waveform. The data field sets both the data hold after SCL falls and the data setup before SCL rises. The low field sets the remaining SCL-low time and also the bus-free gap after a STOP. The high field sets the SCL-high time of a data bit. The condition field sets the timing of START and STOP edges. Any device on the bus may hold SCL low. The engine therefore starts the high phase only once it reads SCL as high through its input synchronizer.

Commands use a valid/ready handshake. Each accepted command ends in a one-cycle `done` pulse, and a read bit returns its sampled level on `rd_bit`.

Top module: `i2c_bit_timer`

## Requirements
- R1: Every timed interval lasts N × 2^(cfg_scale+1) clock cycles, where N is the field that governs it. The tick divider restarts whenever an interval begins.
- R2: START (cmd_op = 0) issued while the bus is free pulls SDA at the accept edge with SCL released. It pulls SCL cond ticks later and pulses `done` on that same edge. cmd_op = 1 issued on a free bus behaves the same way.
- R3: For a data bit (SCL held low at accept), SCL is released (dat + lo + dat) ticks after the accept edge, and SDA does not change on any edge that pulls SCL low.
- R4: After SCL is released, the high phase is counted only from the cycle in which the synchronized SCL input reads high. SCL is therefore pulled low K + SYNC_STAGES + 1 + hi×tick cycles after the release, where K is the number of cycles another device holds the line low. SCL stays released for at least two cycles.
- R5: A write bit (cmd_op = 2) sets sda_pull to the inverse of cmd_wbit, exactly dat ticks after the accept edge.
- R6: A read bit (cmd_op = 3) releases SDA dat ticks after the accept edge and keeps it released through the high phase. It presents the synchronized SDA level on `rd_bit` together with `done`, and `rd_bit` changes at no other time.
- R7: A repeated START (cmd_op = 1) issued while SCL is held releases SDA at accept and releases SCL dat ticks later. It pulls SDA K + SYNC_STAGES + 1 + cond×tick cycles after the SCL release, then pulls SCL cond ticks after that with `done`. cmd_op = 0 issued while SCL is held does the same.
- R8: STOP (cmd_op = 4) pulls SDA at accept and releases SCL dat ticks later. It releases SDA K + SYNC_STAGES + 1 + cond×tick cycles after the SCL release and pulses `done` on that edge.
- R9: After a STOP releases SDA, `cmd_ready` stays low for lo ticks.
- R10: `cmd_ready` is high only while the engine is idle, with the bus either free or held. It falls only on an accepted command, and `done` lasts a single cycle per command.
- R11: A write, read or STOP on a free bus, and cmd_op values 5 to 7 at any time, leave both pull enables unchanged and pulse `done` on the accept edge.
- R12: After reset both pull enables are low, `cmd_ready` is high, and `done` and `rd_bit` are low.
- R13: A timing field of zero acts as one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_scale | input | EXP_W | Prescaler exponent; tick = 2^(cfg_scale+1) clocks |
| cfg_lo_ticks | input | CNT_W | Remaining SCL-low ticks and bus-free ticks |
| cfg_hi_ticks | input | CNT_W | SCL-high ticks of a data bit |
| cfg_cond_ticks | input | CNT_W | START/STOP condition hold and setup ticks |
| cfg_dat_ticks | input | CNT_W | Data hold and data setup ticks |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine can accept a command |
| cmd_op | input | 3 | 0 START, 1 repeated START, 2 write, 3 read, 4 STOP |
| cmd_wbit | input | 1 | Data value of a write bit |
| done | output | 1 | One-cycle completion pulse |
| rd_bit | output | 1 | Level sampled by the last read bit |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_pull | output | 1 | Drive SCL low when high |
| sda_pull | output | 1 | Drive SDA low when high |

## Verification
Clock stretching by another device and the start of high-phase timing can land in the same cycle. SCL release, the line actually rising, and the synchronizer catching it all compete to start the high count. To provoke this, a bus model in the bench holds SCL low for a chosen number of cycles after each release, from zero upward, and varies that number from command to command. The bench judges each high phase, each repeated-START setup and each STOP setup against an interval it computes arithmetically from the stretch length, the synchronizer depth and the tick count, across a sweep of prescaler settings and field sets, including a zero field.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;

  typedef enum logic [2:0] {
    OP_START   = 3'd0,
    OP_RESTART = 3'd1,
    OP_WRITE   = 3'd2,
    OP_READ    = 3'd3,
    OP_STOP    = 3'd4
  } bt_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_OWN,
    S_STA_HOLD,
    S_BIT_HOLD,
    S_BIT_LOW,
    S_BIT_SETUP,
    S_BIT_WAIT,
    S_BIT_HIGH,
    S_RS_REL,
    S_RS_WAIT,
    S_RS_SETUP,
    S_RS_HOLD,
    S_SP_HOLD,
    S_SP_WAIT,
    S_SP_SETUP,
    S_BUSFREE
  } bt_state_e;

endpackage

// File: rtl/i2c_bt_sync.sv
module i2c_bt_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/i2c_bt_phase.sv
module i2c_bt_phase #(
  parameter int CNT_W = 8,
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] ticks,
  input  logic [EXP_W-1:0] scale,
  output logic             fin
);

  localparam int PRE_W = 1 << EXP_W;

  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] lim;
  logic [PRE_W:0]   span;
  logic [EXP_W:0]   shamt;
  logic [CNT_W-1:0] rem;
  logic             active;
  logic             tick;

  always_comb begin
    shamt = {1'b0, scale} + 1'b1;
    span  = (PRE_W+1)'(1) << shamt;
    lim   = PRE_W'(span - 1'b1);
  end

  assign tick = active && (pre == lim);
  assign fin  = tick && (rem == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      pre    <= '0;
      rem    <= '0;
    end else if (load) begin
      active <= 1'b1;
      pre    <= '0;
      rem    <= (ticks == '0) ? CNT_W'(1) : ticks;
    end else if (active) begin
      if (tick) begin
        pre <= '0;
        rem <= rem - 1'b1;
        if (rem == CNT_W'(1)) active <= 1'b0;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
  import i2c_bt_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int EXP_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EXP_W-1:0] cfg_scale,
  input  logic [CNT_W-1:0] cfg_lo_ticks,
  input  logic [CNT_W-1:0] cfg_hi_ticks,
  input  logic [CNT_W-1:0] cfg_cond_ticks,
  input  logic [CNT_W-1:0] cfg_dat_ticks,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic             cmd_wbit,
  output logic             done,
  output logic             rd_bit,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_pull,
  output logic             sda_pull
);

  bt_state_e        st, st_n;
  bt_op_e           op;
  logic             scl_n, sda_n, done_n, rd_n;
  logic             isrd_q, isrd_n, wb_q, wb_n;
  logic             ld, fin, acc;
  logic [CNT_W-1:0] ld_ticks;
  logic [1:0]       lines_s;
  logic             scl_s, sda_s;

  i2c_bt_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_in, sda_in}),
    .q   (lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  i2c_bt_phase #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_phase (
    .clk   (clk),
    .rst   (rst),
    .load  (ld),
    .ticks (ld_ticks),
    .scale (cfg_scale),
    .fin   (fin)
  );

  assign op        = bt_op_e'(cmd_op);
  assign cmd_ready = (st == S_IDLE) || (st == S_OWN);
  assign acc       = cmd_valid && cmd_ready;

  always_comb begin
    st_n     = st;
    scl_n    = scl_pull;
    sda_n    = sda_pull;
    done_n   = 1'b0;
    rd_n     = rd_bit;
    isrd_n   = isrd_q;
    wb_n     = wb_q;
    ld       = 1'b0;
    ld_ticks = cfg_dat_ticks;
    unique case (st)
      S_IDLE: begin
        if (acc) begin
          if (op == OP_START || op == OP_RESTART) begin
            sda_n    = 1'b1;
            ld       = 1'b1;
            ld_ticks = cfg_cond_ticks;
            st_n     = S_STA_HOLD;
          end else begin
            done_n = 1'b1;
          end
        end
      end
      S_OWN: begin
        if (acc) begin
          case (op)
            OP_START, OP_RESTART: begin
              sda_n = 1'b0;
              ld    = 1'b1;
              st_n  = S_RS_REL;
            end
            OP_WRITE, OP_READ: begin
              isrd_n = (op == OP_READ);
              wb_n   = cmd_wbit;
              ld     = 1'b1;
              st_n   = S_BIT_HOLD;
            end
            OP_STOP: begin
              sda_n = 1'b1;
              ld    = 1'b1;
              st_n  = S_SP_HOLD;
            end
            default: done_n = 1'b1;
          endcase
        end
      end
      S_STA_HOLD: begin
        if (fin) begin
          scl_n  = 1'b1;
          done_n = 1'b1;
          st_n   = S_OWN;
        end
      end
      S_BIT_HOLD: begin
        if (fin) begin
          sda_n    = isrd_q ? 1'b0 : !wb_q;
          ld       = 1'b1;
          ld_ticks = cfg_lo_ticks;
          st_n     = S_BIT_LOW;
        end
      end
      S_BIT_LOW: begin
        if (fin) begin
          ld   = 1'b1;
          st_n = S_BIT_SETUP;
        end
      end
      S_BIT_SETUP: begin
        if (fin) begin
          scl_n = 1'b0;
          st_n  = S_BIT_WAIT;
        end
      end
      S_BIT_WAIT: begin
        if (scl_s) begin
          ld       = 1'b1;
          ld_ticks = cfg_hi_ticks;
          st_n     = S_BIT_HIGH;
        end
      end
      S_BIT_HIGH: begin
        if (fin) begin
          scl_n  = 1'b1;
          done_n = 1'b1;
          if (isrd_q) rd_n = sda_s;
          st_n   = S_OWN;
        end
      end
      S_RS_REL: begin
        if (fin) begin
          scl_n = 1'b0;
          st_n  = S_RS_WAIT;
        end
      end
      S_RS_WAIT: begin
        if (scl_s) begin
          ld       = 1'b1;
          ld_ticks = cfg_cond_ticks;
          st_n     = S_RS_SETUP;
        end
      end
      S_RS_SETUP: begin
        if (fin) begin
          sda_n    = 1'b1;
          ld       = 1'b1;
          ld_ticks = cfg_cond_ticks;
          st_n     = S_RS_HOLD;
        end
      end
      S_RS_HOLD: begin
        if (fin) begin
          scl_n  = 1'b1;
          done_n = 1'b1;
          st_n   = S_OWN;
        end
      end
      S_SP_HOLD: begin
        if (fin) begin
          scl_n = 1'b0;
          st_n  = S_SP_WAIT;
        end
      end
      S_SP_WAIT: begin
        if (scl_s) begin
          ld       = 1'b1;
          ld_ticks = cfg_cond_ticks;
          st_n     = S_SP_SETUP;
        end
      end
      S_SP_SETUP: begin
        if (fin) begin
          sda_n    = 1'b0;
          done_n   = 1'b1;
          ld       = 1'b1;
          ld_ticks = cfg_lo_ticks;
          st_n     = S_BUSFREE;
        end
      end
      S_BUSFREE: begin
        if (fin) st_n = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      scl_pull <= 1'b0;
      sda_pull <= 1'b0;
      done     <= 1'b0;
      rd_bit   <= 1'b0;
      isrd_q   <= 1'b0;
      wb_q     <= 1'b0;
    end else begin
      st       <= st_n;
      scl_pull <= scl_n;
      sda_pull <= sda_n;
      done     <= done_n;
      rd_bit   <= rd_n;
      isrd_q   <= isrd_n;
      wb_q     <= wb_n;
    end
  end

endmodule

// File: rtl/i2c_bit_timer_chk.sv
module i2c_bit_timer_chk (
  input logic clk,
  input logic rst,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic done,
  input logic rd_bit,
  input logic scl_pull,
  input logic sda_pull
);

  // R12
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!scl_pull && !sda_pull && !done && cmd_ready));

  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> (!cmd_ready || done));

  // R10
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cmd_ready) |-> $past(cmd_valid));

  // R6
  rd_update_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_bit) |-> done);

  // R4
  scl_release_min_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_pull) |=> !scl_pull);

  // R3
  sda_steady_at_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_pull) |-> $stable(sda_pull));

endmodule

bind i2c_bit_timer i2c_bit_timer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .done      (done),
  .rd_bit    (rd_bit),
  .scl_pull  (scl_pull),
  .sda_pull  (sda_pull)
);

// File: tb/sim_i2c_bit_timer.sv
module sim_i2c_bit_timer;

  localparam int CW   = 4;
  localparam int EW   = 2;
  localparam int SYNC = 2;

  localparam logic [2:0] C_START = 3'd0;
  localparam logic [2:0] C_RS    = 3'd1;
  localparam logic [2:0] C_WR    = 3'd2;
  localparam logic [2:0] C_RD    = 3'd3;
  localparam logic [2:0] C_STOP  = 3'd4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [EW-1:0] cfg_scale = '0;
  logic [CW-1:0] cfg_lo = 4'd1, cfg_hi = 4'd1, cfg_cond = 4'd1, cfg_dat = 4'd1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [2:0]    cmd_op = 3'd0;
  logic          cmd_wbit = 1'b0;
  logic          done, rd_bit, scl_pull, sda_pull;
  logic          scl_in, sda_in;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int rel_cnt = 0;
  int stretch_k = 0;
  logic slave_pull = 1'b0;
  int acc_t = 0;
  int tk = 2, dat_e = 1, lo_e = 1, hi_e = 1, cd_e = 1;
  int dat_raw = 1;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (scl_pull) rel_cnt <= 0;
    else if (rel_cnt < 1000) rel_cnt <= rel_cnt + 1;
  end

  assign scl_in = !scl_pull && (rel_cnt >= stretch_k);
  assign sda_in = !sda_pull && !slave_pull;

  i2c_bit_timer #(.CNT_W(CW), .EXP_W(EW), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst(rst), .cfg_scale(cfg_scale),
    .cfg_lo_ticks(cfg_lo), .cfg_hi_ticks(cfg_hi),
    .cfg_cond_ticks(cfg_cond), .cfg_dat_ticks(cfg_dat),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_wbit(cmd_wbit), .done(done), .rd_bit(rd_bit),
    .scl_in(scl_in), .sda_in(sda_in), .scl_pull(scl_pull), .sda_pull(sda_pull)
  );

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic chk(input string tag, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp_v, cyc);
    end
  endtask

  task automatic set_cfg(input int sc, input int cs);
    int d, l, h, c;
    case (cs)
      0: begin d = 1; l = 2; h = 1; c = 2; end
      1: begin d = 2; l = 3; h = 4; c = 1; end
      2: begin d = 3; l = 1; h = 2; c = 3; end
      default: begin d = 0; l = 2; h = 3; c = 1; end
    endcase
    cfg_scale = EW'(sc);
    cfg_dat = CW'(d); cfg_lo = CW'(l); cfg_hi = CW'(h); cfg_cond = CW'(c);
    dat_raw = d;
    tk = 1 << (sc + 1);
    dat_e = eff(d); lo_e = eff(l); hi_e = eff(h); cd_e = eff(c);
  endtask

  task automatic issue(input logic [2:0] op, input logic b);
    @(negedge clk);
    cmd_op = op; cmd_wbit = b; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    acc_t = cyc;
    cmd_valid = 1'b0;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic wait_scl(input logic v, output int t);
    while (scl_pull != v) @(negedge clk);
    t = cyc;
  endtask

  task automatic wait_sda(input logic v, output int t);
    while (sda_pull != v) @(negedge clk);
    t = cyc;
  endtask

  task automatic wait_ready(output int t);
    while (!cmd_ready) @(negedge clk);
    t = cyc;
  endtask

  task automatic do_start();
    int t;
    issue(C_START, 1'b0);
    chk("R2 sda pulled at accept", sda_pull, 1);
    chk("R2 scl free at accept", scl_pull, 0);
    wait_scl(1'b1, t);
    chk("R2 hold interval", t - acc_t, cd_e * tk);
    chk("R2 done with scl pull", done, 1);
  endtask

  task automatic do_bit(input logic isrd, input logic b, input int k);
    int acc, t, t2;
    stretch_k = k;
    slave_pull = isrd && !b;
    issue(isrd ? C_RD : C_WR, b);
    acc = acc_t;
    chk("R10 busy after accept", cmd_ready, 0);
    wait_until(acc + dat_e * tk);
    if (isrd) chk("R6 sda released after hold", sda_pull, 0);
    else      chk("R5 sda after hold", sda_pull, !b);
    wait_scl(1'b0, t);
    if (dat_raw == 0) chk("R13 zero data field low span", t - acc, (2 * dat_e + lo_e) * tk);
    else              chk("R3 low span", t - acc, (2 * dat_e + lo_e) * tk);
    if (isrd) chk("R6 sda released at scl release", sda_pull, 0);
    wait_scl(1'b1, t2);
    chk("R4 high span with stretch", t2 - t, k + SYNC + 1 + hi_e * tk);
    chk("R10 done at bit end", done, 1);
    if (isrd) chk("R6 read value", rd_bit, b);
    @(negedge clk);
    chk("R10 done single cycle", done, 0);
    slave_pull = 1'b0;
  endtask

  task automatic do_rs(input int k);
    int t, ts, tf;
    stretch_k = k;
    issue(C_RS, 1'b0);
    chk("R7 sda released at accept", sda_pull, 0);
    wait_scl(1'b0, t);
    chk("R7 scl release delay", t - acc_t, dat_e * tk);
    wait_sda(1'b1, ts);
    chk("R7 setup interval", ts - t, k + SYNC + 1 + cd_e * tk);
    wait_scl(1'b1, tf);
    chk("R7 hold interval", tf - ts, cd_e * tk);
    chk("R7 done", done, 1);
  endtask

  task automatic do_stop(input int k);
    int t, ts, tr;
    stretch_k = k;
    issue(C_STOP, 1'b0);
    chk("R8 sda pulled at accept", sda_pull, 1);
    wait_scl(1'b0, t);
    chk("R8 scl release delay", t - acc_t, dat_e * tk);
    wait_sda(1'b0, ts);
    chk("R8 setup interval", ts - t, k + SYNC + 1 + cd_e * tk);
    chk("R8 done", done, 1);
    chk("R9 not ready in bus-free", cmd_ready, 0);
    wait_ready(tr);
    chk("R9 bus-free span", tr - ts, lo_e * tk);
  endtask

  task automatic do_ignored(input logic [2:0] op);
    issue(op, 1'b0);
    chk("R11 done on ignored", done, 1);
    chk("R11 scl unchanged", scl_pull, 0);
    chk("R11 sda unchanged", sda_pull, 0);
    @(negedge clk);
    chk("R10 ready after ignored", cmd_ready, 1);
  endtask

  initial begin
    while (cyc < 150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int t;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 scl_pull", scl_pull, 0);
    chk("R12 sda_pull", sda_pull, 0);
    chk("R12 ready", cmd_ready, 1);
    chk("R12 done", done, 0);
    chk("R12 rd_bit", rd_bit, 0);

    set_cfg(0, 0);
    do_ignored(C_WR);
    do_ignored(C_RD);
    do_ignored(C_STOP);
    do_ignored(3'd6);

    for (int sc = 0; sc < 3; sc++) begin
      for (int cs = 0; cs < 4; cs++) begin
        set_cfg(sc, cs);
        do_start();
        do_bit(1'b0, 1'b1, 0);
        do_bit(1'b0, 1'b0, 2);
        do_bit(1'b1, 1'b0, 1);
        do_bit(1'b1, 1'b1, 0);
        do_rs(sc);
        do_bit(1'b0, 1'b1, cs);
        do_stop(cs);
      end
    end

    // R11: unused code while the bus is held
    set_cfg(0, 0);
    do_start();
    issue(3'd7, 1'b0);
    chk("R11 done on unused code", done, 1);
    chk("R11 scl still held", scl_pull, 1);
    do_stop(0);

    // R1: RESTART on a free bus acts as START, interval scales with prescaler
    set_cfg(2, 2);
    issue(C_RS, 1'b0);
    chk("R2 restart on free bus pulls sda", sda_pull, 1);
    wait_scl(1'b1, t);
    chk("R1 condition interval at scale 2", t - acc_t, 3 * 8);
    do_stop(0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule